// File: doc/BRIEF.md
# Call/Return Stack Sequencer

This block performs the stack memory traffic for subroutine control flow on a 16-bit address space with a byte-wide data bus. It owns the program counter and the stack pointer. On a start pulse it accepts an operation code, a condition-met flag computed elsewhere, a jump target, a restart opcode byte and a word to push. It then issues one byte access at a time through a request/acknowledge port until the sequence is done.

The supported operations are call, conditional call, return, conditional return, restart, push and pop. Stack words are stored little-endian, and the stack grows downward. When a conditional operation's condition is false, the block only steps the program counter past the instruction and touches no memory. A popped accumulator/flag pair has the low nibble of its flag byte cleared. The restart target is formed from bits 5:3 of the opcode byte plus a base address set by a parameter.

Top module: `cs_stack_seq`

## Requirements
- R1: After reset, `busy` and `mem_req` are low and both `pc` and `sp` read 0.
- R2: While idle, `load` copies `load_pc` into `pc` and `load_sp` into `sp`, with priority over `start`.
- R3: Push (op 5) writes the high byte of `push_word` to sp-1 and then the low byte to sp-2. It leaves `sp` at sp-2 and `pc` at pc+1. For an accumulator/flag pair, the caller places the flag byte in bits 15:8.
- R4: Pop (op 6) reads the low byte at sp and then the high byte at sp+1. It leaves `sp` at sp+2 and `pc` at pc+1, and presents the word on `pop_word`.
- R5: All stack pointer arithmetic and all stack addresses wrap modulo 65536.
- R6: Call (op 0), and conditional call (op 1) with `cond_met` high, push pc+3 as in R3 and then set `pc` to `target`.
- R7: Restart (op 4) pushes pc+1 as in R3 and sets `pc` to RST_BASE + 8 × `op_byte[5:3]`.
- R8: A pop with `flag_pair` high clears bits 11:8 of `pop_word`. With `flag_pair` low, all 16 bits are passed through unchanged.
- R9: Conditional call (op 1) or conditional return (op 3) with `cond_met` low issues no memory request and leaves `busy` low. It sets `pc` to pc+3 or pc+1 respectively and leaves `sp` unchanged.
- R10: Return (op 2), and conditional return (op 3) with `cond_met` high, pop a word as in R4 and load it into `pc`.
- R11: `mem_req` stays high, with address, direction and write data held, until `mem_ack` is sampled. `busy` rises only after an accepted `start`. No request is made while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Load pc and sp while idle |
| load_pc | input | 16 | Program counter value for load |
| load_sp | input | 16 | Stack pointer value for load |
| start | input | 1 | Begin an operation (accepted while idle) |
| op | input | 3 | 0 call, 1 cond call, 2 return, 3 cond return, 4 restart, 5 push, 6 pop |
| cond_met | input | 1 | Condition result for conditional ops |
| target | input | 16 | Call destination |
| op_byte | input | 8 | Restart opcode byte; bits 5:3 select the vector |
| push_word | input | 16 | Word pushed by op 5 |
| flag_pair | input | 1 | Pop is the accumulator/flag pair |
| busy | output | 1 | Sequence in progress |
| pc | output | 16 | Program counter |
| sp | output | 16 | Stack pointer |
| pop_word | output | 16 | Last word popped by op 6 |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 16 | Access address |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte, valid with mem_ack |
| mem_ack | input | 1 | Access completed |

## Verification
The bench runs each operation against a memory that acknowledges after a varying delay. It watches for byte order mix-ups: a design that writes the low byte first, or reads the high byte first, shows up at the first stack access. Stack pointers at 0x0001 and 0x0000 catch an address computed without 16-bit wraparound, which would land on the wrong byte. A false condition catches a design that issues stray requests. A flag-pair pop with 0xBE in the high byte catches a missing nibble mask. A normal pop of 0xA55A catches a mask that is applied when it should not be. The restart vector check catches bits taken from the wrong opcode field.

// File: rtl/cs_pkg.sv
package cs_pkg;
  typedef enum logic [2:0] {
    OP_CALL    = 3'd0,
    OP_CALL_IF = 3'd1,
    OP_RET     = 3'd2,
    OP_RET_IF  = 3'd3,
    OP_RST     = 3'd4,
    OP_PUSH    = 3'd5,
    OP_POP     = 3'd6
  } cs_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR_HI,
    ST_WR_LO,
    ST_RD_LO,
    ST_RD_HI
  } cs_state_e;
endpackage

// File: rtl/cs_next_pc.sv
module cs_next_pc
  import cs_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int RST_BASE = 0,
  parameter int CALL_LEN = 3
) (
  input  logic [2:0]        op,
  input  logic [ADDR_W-1:0] pc,
  input  logic [ADDR_W-1:0] target,
  input  logic [7:0]        op_byte,
  output logic [ADDR_W-1:0] seq_pc,
  output logic [ADDR_W-1:0] jump_pc
);
  localparam logic [ADDR_W-1:0] BASE = ADDR_W'(RST_BASE);

  logic is_call;
  assign is_call = (op == OP_CALL) || (op == OP_CALL_IF);

  always_comb begin
    seq_pc  = is_call ? pc + ADDR_W'(CALL_LEN) : pc + ADDR_W'(1);
    jump_pc = is_call ? target
                      : BASE + ADDR_W'({op_byte[5:3], 3'b000});
  end
endmodule

// File: rtl/cs_pop_pack.sv
module cs_pop_pack #(
  parameter int DATA_W    = 8,
  parameter int FLAG_KEEP = 8'hF0
) (
  input  logic [DATA_W-1:0]   hi,
  input  logic [DATA_W-1:0]   lo,
  input  logic                flag_pair,
  output logic [2*DATA_W-1:0] word
);
  localparam logic [DATA_W-1:0] KEEP = DATA_W'(FLAG_KEEP);
  assign word = {flag_pair ? (hi & KEEP) : hi, lo};
endmodule

// File: rtl/cs_stack_seq.sv
module cs_stack_seq
  import cs_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int RST_BASE = 0
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     load,
  input  logic [2*DATA_W-1:0]      load_pc,
  input  logic [2*DATA_W-1:0]      load_sp,
  input  logic                     start,
  input  logic [2:0]               op,
  input  logic                     cond_met,
  input  logic [2*DATA_W-1:0]      target,
  input  logic [7:0]               op_byte,
  input  logic [2*DATA_W-1:0]      push_word,
  input  logic                     flag_pair,
  output logic                     busy,
  output logic [2*DATA_W-1:0]      pc,
  output logic [2*DATA_W-1:0]      sp,
  output logic [2*DATA_W-1:0]      pop_word,
  output logic                     mem_req,
  output logic                     mem_we,
  output logic [2*DATA_W-1:0]      mem_addr,
  output logic [DATA_W-1:0]        mem_wdata,
  input  logic [DATA_W-1:0]        mem_rdata,
  input  logic                     mem_ack
);
  localparam int ADDR_W = 2 * DATA_W;
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] TWO = ADDR_W'(2);

  cs_state_e         st;
  logic [ADDR_W-1:0] word_q, after_pc;
  logic [DATA_W-1:0] lo_q;
  logic              ret_mode, flag_q;
  logic [ADDR_W-1:0] seq_pc, jump_pc, packed_word;
  logic              want_push, want_pop, done_ack;
  logic [ADDR_W-1:0] push_val, push_dest;

  cs_next_pc #(.ADDR_W(ADDR_W), .RST_BASE(RST_BASE), .CALL_LEN(3)) u_next (
    .op(op), .pc(pc), .target(target), .op_byte(op_byte),
    .seq_pc(seq_pc), .jump_pc(jump_pc)
  );

  cs_pop_pack #(.DATA_W(DATA_W), .FLAG_KEEP(8'hF0)) u_pack (
    .hi(mem_rdata), .lo(lo_q), .flag_pair(flag_q), .word(packed_word)
  );

  always_comb begin
    want_push = (op == OP_CALL) || (op == OP_RST) || (op == OP_PUSH) ||
                ((op == OP_CALL_IF) && cond_met);
    want_pop  = (op == OP_RET) || (op == OP_POP) ||
                ((op == OP_RET_IF) && cond_met);
    push_val  = (op == OP_PUSH) ? push_word : seq_pc;
    push_dest = (op == OP_PUSH) ? seq_pc : jump_pc;
    done_ack  = mem_req && mem_ack;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      busy      <= 1'b0;
      pc        <= '0;
      sp        <= '0;
      pop_word  <= '0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      word_q    <= '0;
      after_pc  <= '0;
      lo_q      <= '0;
      ret_mode  <= 1'b0;
      flag_q    <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: begin
          if (load) begin
            pc <= load_pc;
            sp <= load_sp;
          end else if (start) begin
            if (want_push) begin
              st        <= ST_WR_HI;
              busy      <= 1'b1;
              mem_req   <= 1'b1;
              mem_we    <= 1'b1;
              mem_addr  <= sp - ONE;
              mem_wdata <= push_val[ADDR_W-1:DATA_W];
              word_q    <= push_val;
              after_pc  <= push_dest;
              sp        <= sp - ONE;
            end else if (want_pop) begin
              st       <= ST_RD_LO;
              busy     <= 1'b1;
              mem_req  <= 1'b1;
              mem_we   <= 1'b0;
              mem_addr <= sp;
              ret_mode <= (op != OP_POP);
              flag_q   <= flag_pair;
              after_pc <= seq_pc;
            end else begin
              pc <= seq_pc;
            end
          end
        end
        ST_WR_HI: if (done_ack) begin
          st        <= ST_WR_LO;
          mem_addr  <= sp - ONE;
          mem_wdata <= word_q[DATA_W-1:0];
          sp        <= sp - ONE;
        end
        ST_WR_LO: if (done_ack) begin
          st      <= ST_IDLE;
          busy    <= 1'b0;
          mem_req <= 1'b0;
          mem_we  <= 1'b0;
          pc      <= after_pc;
        end
        ST_RD_LO: if (done_ack) begin
          st       <= ST_RD_HI;
          lo_q     <= mem_rdata;
          mem_addr <= sp + ONE;
        end
        ST_RD_HI: if (done_ack) begin
          st      <= ST_IDLE;
          busy    <= 1'b0;
          mem_req <= 1'b0;
          sp      <= sp + TWO;
          if (ret_mode) pc <= {mem_rdata, lo_q};
          else begin
            pc       <= after_pc;
            pop_word <= packed_word;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cs_stack_seq_chk.sv
module cs_stack_seq_chk
  import cs_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic [2:0]        op,
  input logic              cond_met,
  input logic              busy,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_ack,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata
);
  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) &&
                               $stable(mem_we) && $stable(mem_wdata)));

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_req);

  // R11
  busy_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));

  // R3
  push_descend_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_ack && mem_we) |=>
      (!mem_req || (mem_we && mem_addr == $past(mem_addr) - ADDR_W'(1))));

  // R4
  pop_ascend_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_ack && !mem_we) |=>
      (!mem_req || (!mem_we && mem_addr == $past(mem_addr) + ADDR_W'(1))));

  // R9
  skip_no_mem_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && !cond_met &&
     (op == OP_CALL_IF || op == OP_RET_IF)) |=> (!busy && !mem_req));
endmodule

bind cs_stack_seq cs_stack_seq_chk #(.ADDR_W(2*DATA_W), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst(rst), .start(start), .op(op), .cond_met(cond_met),
  .busy(busy), .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata)
);

// File: tb/cs_stack_seq_tb.sv
module cs_stack_seq_tb_top;
  localparam int RBASE = 16'h0100;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        load = 1'b0, start = 1'b0, cond_met = 1'b0, flag_pair = 1'b0;
  logic [15:0] load_pc = '0, load_sp = '0, target = '0, push_word = '0;
  logic [2:0]  op = '0;
  logic [7:0]  op_byte = '0;
  logic        busy, mem_req, mem_we;
  logic [15:0] pc, sp, pop_word, mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = '0;
  logic        mem_ack = 1'b0;

  always #5 clk = ~clk;

  cs_stack_seq #(.DATA_W(8), .RST_BASE(RBASE)) dut_i (
    .clk(clk), .rst(rst), .load(load), .load_pc(load_pc), .load_sp(load_sp),
    .start(start), .op(op), .cond_met(cond_met), .target(target),
    .op_byte(op_byte), .push_word(push_word), .flag_pair(flag_pair),
    .busy(busy), .pc(pc), .sp(sp), .pop_word(pop_word),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  int checks = 0, errors = 0, cycles = 0;
  logic [7:0]  mem    [int];
  logic [7:0]  shadow [int];
  logic [15:0] exp_a [$];
  bit          exp_w [$];
  logic [7:0]  exp_d [$];
  logic [15:0] m_pc = '0, m_sp = '0, m_pop = '0;
  int          wcnt = 0, dly = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      finish_run();
    end
  end

  // Memory responder with varying acknowledge delay; checks each access (R3 R4 R11)
  always @(negedge clk) begin
    if (mem_ack) begin
      mem_ack = 1'b0;
      dly++;
      wcnt = dly % 3;
    end else if (mem_req) begin
      if (wcnt > 0) wcnt--;
      else begin
        if (exp_a.size() == 0) begin
          chk("R11 unexpected request", {15'd0, mem_we, mem_addr}, 32'hFFFF_FFFF);
        end else begin
          logic [15:0] ea; bit ew; logic [7:0] ed;
          ea = exp_a.pop_front(); ew = exp_w.pop_front(); ed = exp_d.pop_front();
          chk("R3/R4 access address", {16'd0, mem_addr}, {16'd0, ea});
          chk("R3/R4 access direction", {31'd0, mem_we}, {31'd0, ew});
          if (ew) chk("R3 write byte", {24'd0, mem_wdata}, {24'd0, ed});
        end
        if (mem_we) mem[int'(mem_addr)] = mem_wdata;
        else mem_rdata = mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : 8'h00;
        mem_ack = 1'b1;
      end
    end
  end

  function automatic logic [7:0] sh(input logic [15:0] a);
    return shadow.exists(int'(a)) ? shadow[int'(a)] : 8'h00;
  endfunction

  task automatic do_op(input string req, input logic [2:0] o, input bit c,
                       input logic [15:0] tgt, input logic [15:0] pw,
                       input logic [7:0] ob, input bit fp);
    logic [15:0] w, a1, a2;
    // reference model
    if (o == 3'd0 || (o == 3'd1 && c) || o == 3'd4 || o == 3'd5) begin
      w  = (o == 3'd5) ? pw : ((o == 3'd4) ? m_pc + 16'd1 : m_pc + 16'd3);
      a1 = m_sp - 16'd1; a2 = m_sp - 16'd2;
      exp_a.push_back(a1); exp_w.push_back(1'b1); exp_d.push_back(w[15:8]);
      exp_a.push_back(a2); exp_w.push_back(1'b1); exp_d.push_back(w[7:0]);
      shadow[int'(a1)] = w[15:8]; shadow[int'(a2)] = w[7:0];
      m_sp = a2;
      if (o == 3'd5)      m_pc = m_pc + 16'd1;
      else if (o == 3'd4) m_pc = 16'(RBASE) + 16'(ob[5:3]) * 16'd8;
      else                m_pc = tgt;
    end else if (o == 3'd2 || (o == 3'd3 && c) || o == 3'd6) begin
      a1 = m_sp; a2 = m_sp + 16'd1;
      exp_a.push_back(a1); exp_w.push_back(1'b0); exp_d.push_back(8'h00);
      exp_a.push_back(a2); exp_w.push_back(1'b0); exp_d.push_back(8'h00);
      w = {sh(a2), sh(a1)};
      m_sp = m_sp + 16'd2;
      if (o == 3'd6) begin
        m_pc  = m_pc + 16'd1;
        m_pop = fp ? {w[15:12], 4'h0, w[7:0]} : w;
      end else m_pc = w;
    end else begin
      m_pc = m_pc + ((o == 3'd1) ? 16'd3 : 16'd1);
    end
    // drive
    @(negedge clk);
    op = o; cond_met = c; target = tgt; push_word = pw; op_byte = ob;
    flag_pair = fp; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (busy) @(negedge clk);
    chk({req, " pc"}, {16'd0, pc}, {16'd0, m_pc});
    chk({req, " sp"}, {16'd0, sp}, {16'd0, m_sp});
    chk({req, " all accesses made"}, exp_a.size(), 0);
    if (o == 3'd6) chk({req, " pop_word"}, {16'd0, pop_word}, {16'd0, m_pop});
  endtask

  task automatic do_load(input logic [15:0] p, input logic [15:0] s);
    @(negedge clk);
    load = 1'b1; load_pc = p; load_sp = s;
    @(negedge clk);
    load = 1'b0;
    m_pc = p; m_sp = s;
    chk("R2 load pc", {16'd0, pc}, {16'd0, p});
    chk("R2 load sp", {16'd0, sp}, {16'd0, s});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 busy", {31'd0, busy}, 0);
    chk("R1 mem_req", {31'd0, mem_req}, 0);
    chk("R1 pc", {16'd0, pc}, 0);
    chk("R1 sp", {16'd0, sp}, 0);

    do_load(16'h1234, 16'hFFFE);
    do_op("R3 push", 3'd5, 1'b0, 16'h0, 16'hBEEF, 8'h00, 1'b0);
    do_op("R6 call", 3'd0, 1'b0, 16'h4000, 16'h0, 8'h00, 1'b0);
    do_op("R9 cond call false", 3'd1, 1'b0, 16'h7777, 16'h0, 8'h00, 1'b0);
    do_op("R7 restart", 3'd4, 1'b0, 16'h0, 16'h0, 8'hEF, 1'b0);
    do_op("R10 return", 3'd2, 1'b0, 16'h0, 16'h0, 8'h00, 1'b0);
    do_op("R9 cond return false", 3'd3, 1'b0, 16'h0, 16'h0, 8'h00, 1'b0);
    do_op("R6 cond call true", 3'd1, 1'b1, 16'h5A00, 16'h0, 8'h00, 1'b0);
    do_op("R10 cond return true", 3'd3, 1'b1, 16'h0, 16'h0, 8'h00, 1'b0);
    do_op("R10 return to first call", 3'd2, 1'b0, 16'h0, 16'h0, 8'h00, 1'b0);
    do_op("R8 flag pair pop", 3'd6, 1'b0, 16'h0, 16'h0, 8'h00, 1'b1);

    do_load(16'h0200, 16'h0001);
    do_op("R5 push across zero", 3'd5, 1'b0, 16'h0, 16'hA55A, 8'h00, 1'b0);
    do_op("R8 plain pop unmasked", 3'd6, 1'b0, 16'h0, 16'h0, 8'h00, 1'b0);
    do_load(16'h0300, 16'h0000);
    do_op("R5 restart from sp zero", 3'd4, 1'b0, 16'h0, 16'h0, 8'hC7, 1'b0);
    do_op("R5 return across top", 3'd2, 1'b0, 16'h0, 16'h0, 8'h00, 1'b0);
    do_op("R7 restart vector 7", 3'd4, 1'b0, 16'h0, 16'h0, 8'hFF, 1'b0);
    chk("R7 vector 7 address", {16'd0, pc}, {16'd0, 16'(RBASE) + 16'h0038});
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule